// File: doc/BRIEF.md
# Single-Wire Pulse-Width Serial Slave

This block is the device end of a one-pin, open-drain serial link where every bit is carried by how long the line stays low. It waits for the host to hold the line low long enough to count as a break, followed by a short high recovery. It then reads a command byte. Bit 7 of that byte selects a write or a read, and bits 6:0 give a register address. A write is followed by a data byte from the host, which is handed to the register file with a one-cycle strobe. A read is answered after a fixed turnaround: the slave pulls the line low in eight timed slots, and the width of each low pulse encodes one bit.

All timing is kept in whole microseconds and scaled by the `CLK_PER_US` parameter. The line input is synchronised and filtered for glitches before any edge is measured. The block only ever drives the line low, and it does so only while it is sending response bits. If the host holds the line low for the reset time, the block gives a one-cycle line-reset pulse and drops whatever transaction was in progress.

Top module: `spw_slave`

## Requirements
- R1: After reset, the line is released (`line_drive_low` = 0), `reg_we` = 0 and `line_reset` = 0.
- R2: A host bit is a low pulse. It decodes as 1 if the line returns high less than 68 us after the falling edge, and as 0 otherwise. Bytes arrive least-significant bit first. In the command byte, bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 are the register address.
- R3: In a write, after the 8th data bit `reg_we` is high for exactly one cycle, with `reg_addr` and `reg_wdata` holding the decoded address and data. No other stimulus raises `reg_we`.
- R4: In a read, `reg_rdata` is sampled for the address on `reg_addr` and sent least-significant bit first in 8 slots of 205 us. A 1 is a 40 us low and a 0 is a 110 us low. `reg_addr` stays fixed while the bits are sent.
- R5: The first response low begins between 190 us and 950 us after the host releases the line at the end of the last command bit.
- R6: A low longer than 145 us counts as a break. It arms reception only when it is followed by at least 40 us of high. If the line falls earlier, reception stays disarmed and no bits are decoded until the next break.
- R7: A break seen in the middle of a command or data byte discards the partial byte and starts a new transaction.
- R8: A low lasting `RESET_US` gives exactly one `line_reset` pulse and discards the transaction. Bits sent after that without a new break are ignored.
- R9: Line changes that last fewer than `GLITCH_CYC` clock cycles, in either direction, do not change the decoded bits.
- R10: `line_drive_low` is asserted only while response bits are being sent, never during writes or idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sensed level of the shared serial line |
| line_drive_low | output | 1 | 1 = pull the line low (open-drain enable) |
| reg_addr | output | 7 | Register address decoded from the command byte |
| reg_wdata | output | 8 | Write data decoded from the host |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |
| line_reset | output | 1 | One-cycle pulse when a reset-length low is seen |

## Verification
The assertions assume the host keeps to the pulse classes. Its short lows stay well under 68 us, its long lows lie between 68 and 145 us, its breaks exceed 145 us, and it stays silent while the slave answers. The directed bench keeps to this by using 10 us for a 1, 110 us for a 0, 250 us breaks and 190 us bit cycles. Only the glitch, short-recovery and reset scenarios step outside these limits, and each does so on purpose. `reg_rdata` is modelled as a combinational function of `reg_addr`, so the assertion that the address holds during sending is what keeps the transmitted byte consistent.

// File: rtl/spw_pkg.sv
package spw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOV,
        ST_CMD,
        ST_WDATA,
        ST_TURN,
        ST_SEND
    } spw_state_t;
endpackage

// File: rtl/spw_line_filter.sv
module spw_line_filter #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_clean
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [1:0]    sync_d, sync_q;
    logic          clean_d, clean_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        sync_d  = {sync_q[0], line_raw};
        clean_d = clean_q;
        cnt_d   = '0;
        if (sync_q[1] != clean_q) begin
            if (cnt_q == CW'(GLITCH_CYC - 1)) begin
                clean_d = sync_q[1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            clean_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            sync_q  <= sync_d;
            clean_q <= clean_d;
            cnt_q   <= cnt_d;
        end
    end

    assign line_clean = clean_q;
endmodule

// File: rtl/spw_low_timer.sv
module spw_low_timer #(
    parameter int RESET_CYC = 1000,
    parameter int CNT_W     = $clog2(RESET_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_clean,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] low_width,
    output logic             hold_reset
);
    logic             prev_d, prev_q;
    logic [CNT_W-1:0] low_d, low_q;

    always_comb begin
        prev_d = line_clean;
        if (line_clean) begin
            low_d = '0;
        end else if (low_q != CNT_W'(RESET_CYC)) begin
            low_d = low_q + 1'b1;
        end else begin
            low_d = low_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            low_q  <= '0;
        end else begin
            prev_q <= prev_d;
            low_q  <= low_d;
        end
    end

    assign rise       = line_clean & ~prev_q;
    assign fall       = ~line_clean & prev_q;
    assign low_width  = low_q;
    assign hold_reset = ~line_clean && (low_q == CNT_W'(RESET_CYC - 1));
endmodule

// File: rtl/spw_slave.sv
module spw_slave
    import spw_pkg::*;
#(
    parameter int CLK_PER_US   = 8,
    parameter int GLITCH_CYC   = 3,
    parameter int SAMPLE_US    = 68,
    parameter int HOST0_MAX_US = 145,
    parameter int RECOV_US     = 40,
    parameter int RESP_US      = 200,
    parameter int SLOT_US      = 205,
    parameter int SEND1_US     = 40,
    parameter int SEND0_US     = 110,
    parameter int RESET_US     = 1800000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic       line_drive_low,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    output logic       line_reset
);
    localparam int SAMPLE_CYC = SAMPLE_US * CLK_PER_US;
    localparam int HOST0_CYC  = HOST0_MAX_US * CLK_PER_US;
    localparam int RECOV_CYC  = RECOV_US * CLK_PER_US;
    localparam int RESP_CYC   = RESP_US * CLK_PER_US;
    localparam int SLOT_CYC   = SLOT_US * CLK_PER_US;
    localparam int SEND1_CYC  = SEND1_US * CLK_PER_US;
    localparam int SEND0_CYC  = SEND0_US * CLK_PER_US;
    localparam int RESET_CYC  = RESET_US * CLK_PER_US;
    localparam int CNT_W      = $clog2(RESET_CYC + 1);
    localparam int TMR_A      = (RESP_CYC > SLOT_CYC) ? RESP_CYC : SLOT_CYC;
    localparam int TMR_MAX    = (TMR_A > RECOV_CYC) ? TMR_A : RECOV_CYC;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    typedef struct packed {
        spw_state_t        state;
        logic [2:0]        bit_idx;
        logic [7:0]        shreg;
        logic [TMR_W-1:0]  tmr;
        logic [6:0]        addr;
        logic [7:0]        wdata;
        logic              we;
        logic              drive;
        logic              lreset;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic             line_clean;
    logic             rise, fall, hold_reset;
    logic [CNT_W-1:0] low_width;
    logic             bit_val, long_low, sat_low;
    logic [7:0]       byte_full;
    logic [TMR_W-1:0] low_len;
    spw_state_t       state_q;

    spw_line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .line_clean(line_clean)
    );

    spw_low_timer #(.RESET_CYC(RESET_CYC), .CNT_W(CNT_W)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clean(line_clean),
        .rise      (rise),
        .fall      (fall),
        .low_width (low_width),
        .hold_reset(hold_reset)
    );

    always_comb begin
        bit_val   = (low_width < CNT_W'(SAMPLE_CYC));
        sat_low   = rise && (low_width == CNT_W'(RESET_CYC));
        long_low  = rise && (low_width > CNT_W'(HOST0_CYC));
        byte_full = {bit_val, cur_q.shreg[7:1]};
        low_len   = cur_q.shreg[0] ? TMR_W'(SEND1_CYC) : TMR_W'(SEND0_CYC);

        nxt_d        = cur_q;
        nxt_d.we     = 1'b0;
        nxt_d.lreset = 1'b0;

        unique case (cur_q.state)
            ST_IDLE: ;
            ST_RECOV: begin
                if (fall) begin
                    nxt_d.state = ST_IDLE;
                end else if (cur_q.tmr == TMR_W'(RECOV_CYC - 1)) begin
                    nxt_d.state   = ST_CMD;
                    nxt_d.bit_idx = '0;
                end else begin
                    nxt_d.tmr = cur_q.tmr + 1'b1;
                end
            end
            ST_CMD: begin
                if (rise) begin
                    nxt_d.shreg   = byte_full;
                    nxt_d.bit_idx = cur_q.bit_idx + 1'b1;
                    if (cur_q.bit_idx == 3'd7) begin
                        nxt_d.addr    = byte_full[6:0];
                        nxt_d.bit_idx = '0;
                        nxt_d.tmr     = '0;
                        nxt_d.state   = byte_full[7] ? ST_WDATA : ST_TURN;
                    end
                end
            end
            ST_WDATA: begin
                if (rise) begin
                    nxt_d.shreg   = byte_full;
                    nxt_d.bit_idx = cur_q.bit_idx + 1'b1;
                    if (cur_q.bit_idx == 3'd7) begin
                        nxt_d.wdata = byte_full;
                        nxt_d.we    = 1'b1;
                        nxt_d.state = ST_IDLE;
                    end
                end
            end
            ST_TURN: begin
                if (cur_q.tmr == TMR_W'(RESP_CYC - 1)) begin
                    nxt_d.state   = ST_SEND;
                    nxt_d.shreg   = reg_rdata;
                    nxt_d.bit_idx = '0;
                    nxt_d.tmr     = '0;
                    nxt_d.drive   = 1'b1;
                end else begin
                    nxt_d.tmr = cur_q.tmr + 1'b1;
                end
            end
            ST_SEND: begin
                nxt_d.tmr = cur_q.tmr + 1'b1;
                if (cur_q.tmr == low_len - 1'b1) begin
                    nxt_d.drive = 1'b0;
                end
                if (cur_q.tmr == TMR_W'(SLOT_CYC - 1)) begin
                    nxt_d.tmr = '0;
                    if (cur_q.bit_idx == 3'd7) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.drive = 1'b0;
                    end else begin
                        nxt_d.bit_idx = cur_q.bit_idx + 1'b1;
                        nxt_d.shreg   = {1'b0, cur_q.shreg[7:1]};
                        nxt_d.drive   = 1'b1;
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase

        // Line-level events take priority over the sequence above
        if (hold_reset) begin
            nxt_d.state  = ST_IDLE;
            nxt_d.lreset = 1'b1;
            nxt_d.drive  = 1'b0;
            nxt_d.we     = 1'b0;
        end else if (sat_low) begin
            nxt_d.state = ST_IDLE;
            nxt_d.drive = 1'b0;
        end else if (long_low) begin
            nxt_d.state   = ST_RECOV;
            nxt_d.tmr     = '0;
            nxt_d.bit_idx = '0;
            nxt_d.drive   = 1'b0;
            nxt_d.we      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, bit_idx: '0, shreg: '0, tmr: '0,
                       addr: '0, wdata: '0, we: 1'b0, drive: 1'b0, lreset: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_q        = cur_q.state;
    assign line_drive_low = cur_q.drive;
    assign reg_addr       = cur_q.addr;
    assign reg_wdata      = cur_q.wdata;
    assign reg_we         = cur_q.we;
    assign line_reset     = cur_q.lreset;
endmodule

// File: rtl/spw_slave_chk.sv
module spw_slave_chk
    import spw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       line_drive_low,
    input logic       reg_we,
    input logic       line_reset,
    input logic [6:0] reg_addr,
    input spw_state_t state
);
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r3_strobe_ends_txn: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state == ST_IDLE));

    a_r10_drive_only_sending: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> (state == ST_SEND));

    a_r8_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |=> !line_reset);

    a_r8_reset_drops_txn: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |-> (state == ST_IDLE && !line_drive_low && !reg_we));

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && $past(state) == ST_SEND) |-> $stable(reg_addr));

    a_r5_send_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SEND) |-> ($past(state) == ST_TURN && line_drive_low));
endmodule

bind spw_slave spw_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_drive_low(line_drive_low),
    .reg_we        (reg_we),
    .line_reset    (line_reset),
    .reg_addr      (reg_addr),
    .state         (state_q)
);

// File: tb/sim_spw_slave.sv
`timescale 1ns/1ps
module sim_spw_slave;
    localparam int CPU = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       line_in;
    logic       line_drive_low;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       line_reset;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int rst_cnt = 0;
    int drive_cnt = 0;
    logic [6:0] cap_addr;
    logic [7:0] cap_data;

    always #10 clk = ~clk;

    assign line_in = ~(host_low | line_drive_low);

    function automatic logic [7:0] rd_model(input logic [6:0] a);
        if (a == 7'h01) return 8'h00;
        if (a == 7'h02) return 8'hFF;
        return {1'b0, a} ^ 8'h93;
    endfunction

    assign reg_rdata = rd_model(reg_addr);

    spw_slave #(.CLK_PER_US(CPU), .RESET_US(2000)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .line_drive_low(line_drive_low),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_we        (reg_we),
        .reg_rdata     (reg_rdata),
        .line_reset    (line_reset)
    );

    always @(negedge clk) begin
        if (reg_we) begin
            we_cnt++;
            cap_addr = reg_addr;
            cap_data = reg_wdata;
        end
        if (line_reset) rst_cnt++;
        if (line_drive_low) drive_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * CPU) @(negedge clk);
    endtask

    task automatic host_pulse(input int us);
        host_low = 1'b1;
        wait_us(us);
        host_low = 1'b0;
    endtask

    task automatic send_break();
        host_pulse(250);
        wait_us(60);
    endtask

    task automatic send_bit(input logic b);
        if (b) begin host_pulse(10); wait_us(180); end
        else   begin host_pulse(110); wait_us(80); end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_bit_glitchy(input logic b);
        host_low = 1'b1;
        if (b) begin
            wait_us(10);
        end else begin
            wait_us(50);
            host_low = 1'b0; @(negedge clk);
            host_low = 1'b1; wait_us(60);
        end
        host_low = 1'b0;
        wait_us(60);
        host_low = 1'b1; @(negedge clk);
        host_low = 1'b0;
        wait_us(b ? 120 : 20);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
        int w0, dr0;
        w0 = we_cnt; dr0 = drive_cnt;
        send_break();
        send_byte({1'b1, a});
        send_byte(d);
        wait_us(20);
        chk(we_cnt == w0 + 1, req, "write strobe count", we_cnt - w0, 1);
        chk(cap_addr == a, req, "write address", cap_addr, a);
        chk(cap_data == d, req, "write data", cap_data, d);
        chk(drive_cnt == dr0, "R10", "line driven during write", drive_cnt - dr0, 0);
        wait_us(300);
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [7:0] cmd, exp, got;
        int cnt, w, g;
        cmd = {1'b0, a};
        exp = rd_model(a);
        got = '0;
        send_break();
        for (int i = 0; i < 7; i++) send_bit(cmd[i]);
        host_pulse(110);
        cnt = 0;
        while (!line_drive_low && cnt < 2000 * CPU) begin @(negedge clk); cnt++; end
        chk(cnt >= 190 * CPU && cnt <= 950 * CPU, "R5", "response delay cycles", cnt, 200 * CPU);
        for (int i = 0; i < 8; i++) begin
            w = 0;
            while (line_drive_low && w < 1000 * CPU) begin @(negedge clk); w++; end
            got[i] = (w < 68 * CPU);
            if (exp[i]) chk(w >= 32 * CPU && w <= 50 * CPU, "R4", "one-bit low width", w, 40 * CPU);
            else        chk(w >= 80 * CPU && w <= 145 * CPU, "R4", "zero-bit low width", w, 110 * CPU);
            if (i < 7) begin
                g = 0;
                while (!line_drive_low && g < 1000 * CPU) begin @(negedge clk); g++; end
                chk(w + g >= 190 * CPU && w + g <= 250 * CPU, "R4", "slot length", w + g, 205 * CPU);
            end
        end
        chk(got == exp, req, "read byte", got, exp);
        wait_us(300);
        chk(!line_drive_low, "R10", "line released after read", line_drive_low, 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(!line_drive_low, "R1", "drive after reset", line_drive_low, 0);
        chk(!reg_we, "R1", "strobe after reset", reg_we, 0);
        chk(!line_reset, "R1", "line reset after reset", line_reset, 0);
    endtask

    task automatic t_abort();
        send_break();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_write(7'h4C, 8'h3E, "R7");
    endtask

    task automatic t_short_recovery();
        int w0;
        w0 = we_cnt;
        host_pulse(250);
        wait_us(10);
        send_byte(8'h85);
        send_byte(8'h66);
        wait_us(50);
        chk(we_cnt == w0, "R6", "strobe after short recovery", we_cnt - w0, 0);
        wait_us(300);
    endtask

    task automatic t_line_reset();
        int w0, r0;
        w0 = we_cnt; r0 = rst_cnt;
        send_break();
        send_bit(1'b1); send_bit(1'b1);
        host_pulse(2100);
        wait_us(60);
        chk(rst_cnt == r0 + 1, "R8", "line reset pulses", rst_cnt - r0, 1);
        send_byte(8'h90);
        send_byte(8'h11);
        wait_us(50);
        chk(we_cnt == w0, "R8", "strobe without new break", we_cnt - w0, 0);
        wait_us(300);
        do_write(7'h0F, 8'hE1, "R8");
    endtask

    task automatic t_glitch();
        int w0;
        logic [7:0] d;
        w0 = we_cnt;
        d = 8'h5A;
        send_break();
        send_byte({1'b1, 7'h33});
        for (int i = 0; i < 8; i++) send_bit_glitchy(d[i]);
        wait_us(20);
        chk(we_cnt == w0 + 1, "R9", "strobe with glitches", we_cnt - w0, 1);
        chk(cap_data == d, "R9", "data with glitches", cap_data, d);
        wait_us(300);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        do_write(7'h15, 8'hA7, "R3");
        do_write(7'h7F, 8'h00, "R2");
        do_read(7'h2A, "R4");
        do_read(7'h01, "R2");
        do_read(7'h02, "R4");
        t_abort();
        t_short_recovery();
        t_line_reset();
        t_glitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule